// File: doc/BRIEF.md
# DRAM PHY Training Mailbox Monitor

This block replaces the firmware loop that watches a DRAM PHY while it trains. After a start pulse it uses a simple register read/write port to poll the PHY's mailbox status. It reads each major message and acknowledges it with a two-phase handshake. It keeps doing this until the PHY reports either a pass or a failure.

Three major message codes control the block. A pass code sets a sticky done flag and a failure code sets a sticky fail flag; in both cases the block goes quiet on the bus. A stream code means a run of 32-bit words follows. The first of these words gives, in its low half, how many more words come after it. The block reads and acknowledges every word and shows each one on a debug port, together with a one-cycle strobe. Any other code is acknowledged and then ignored.

Top module: `phy_msg_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it, `train_done`, `train_fail`, `stream_valid`, `bus_re` and `bus_we` are all 0.
- R2: The block makes no bus access until `start` is pulsed while it is idle.
- R3: A message counts as pending only when a read of the status register (address 0x10) returns bit 0 equal to 0. Until then the block keeps polling, with no timeout, and reads no message register.
- R4: A major message is fetched with a single read of the low message register (address 0x20). The high register is not read for it.
- R5: A stream word is assembled as {high register (0x21), low register (0x20)}, and the high register is read first.
- R6: Every fetched message is acknowledged in three steps. The block writes 0 to the acknowledge register (0x30), polls status until bit 0 reads 1, then writes 1 to the acknowledge register.
- R7: Major code 0x07 sets `train_done`. The flag stays set until the next accepted `start` and is never set at the same time as `train_fail`.
- R8: Major code 0xFF sets `train_fail`. The flag stays set until the next accepted `start`, and the block makes no further bus access.
- R9: Major code 0x08 makes the block fetch one count word, then N more stream words, where N is the count word's bits [15:0]. Each word appears on `stream_word` with a one-cycle `stream_valid` pulse. If N is 0, the block goes straight back to waiting for major messages.
- R10: Any other major code is acknowledged and ignored. The block then waits for the next major message.
- R11: `bus_re` and `bus_we` are never high in the same cycle, and read data is taken one cycle after `bus_re`.
- R12: An accepted `start` clears `train_done` and `train_fail` on the next edge. A `start` pulse during a training run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin monitoring (accepted when idle or finished) |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Read data, valid one cycle after `bus_re` |
| train_done | output | 1 | Sticky training-pass flag |
| train_fail | output | 1 | Sticky training-failure flag |
| stream_word | output | 2*DATA_W | Most recent stream word |
| stream_valid | output | 1 | One-cycle strobe for `stream_word` |

## Verification
Some properties are checked on every cycle. The bus never reads and writes in the same cycle. The done and fail flags are mutually exclusive and stay set until a start. A failure leaves the bus silent. A 1 is never written to the acknowledge register without a preceding 0. Other behaviour can only be shown by the bench's scripted PHY model: waiting for the pending flag, waiting for the release flag before the final acknowledge, taking the stream length from the count word, skipping unknown codes, and the exact read counts on the high and low registers. A scoreboard compares every streamed word in order.

// File: rtl/phy_mon_pkg.sv
package phy_mon_pkg;
  typedef enum logic [3:0] {
    F_IDLE, F_POLL_RD, F_POLL_WT, F_HI_RD, F_HI_WT, F_LO_RD, F_LO_WT,
    F_ACK0, F_REL_RD, F_REL_WT, F_ACK1
  } fetch_st_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_CNT, S_DRAIN, S_HALT
  } ctl_st_t;
endpackage

// File: rtl/phy_mon_fetch.sv
module phy_mon_fetch
  import phy_mon_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STATUS_ADDR = 16,
  parameter int LO_ADDR     = 32,
  parameter int HI_ADDR     = 33,
  parameter int ACK_ADDR    = 48,
  parameter int READY_BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic                  want_stream,
  output logic                  done,
  output logic [2*DATA_W-1:0]   word,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_we,
  output logic                  bus_re,
  input  logic [DATA_W-1:0]     bus_rdata
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ACK_ADDR);

  fetch_st_t state, state_n;
  logic stream_q;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic [ADDR_W-1:0] addr_n;
  logic ready_bit;

  assign ready_bit = bus_rdata[READY_BIT];

  always_comb begin
    state_n = state;
    unique case (state)
      F_IDLE:    if (go) state_n = F_POLL_RD;
      F_POLL_RD: state_n = F_POLL_WT;
      F_POLL_WT: begin
        if (ready_bit) state_n = F_POLL_RD;
        else if (stream_q) state_n = F_HI_RD;
        else state_n = F_LO_RD;
      end
      F_HI_RD:   state_n = F_HI_WT;
      F_HI_WT:   state_n = F_LO_RD;
      F_LO_RD:   state_n = F_LO_WT;
      F_LO_WT:   state_n = F_ACK0;
      F_ACK0:    state_n = F_REL_RD;
      F_REL_RD:  state_n = F_REL_WT;
      F_REL_WT:  state_n = ready_bit ? F_ACK1 : F_REL_RD;
      F_ACK1:    state_n = F_IDLE;
      default:   state_n = F_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_n)
      F_POLL_RD, F_REL_RD: addr_n = A_STAT;
      F_HI_RD:             addr_n = A_HI;
      F_LO_RD:             addr_n = A_LO;
      F_ACK0, F_ACK1:      addr_n = A_ACK;
      default:             addr_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      stream_q  <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      done      <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      state     <= state_n;
      done      <= (state == F_ACK1);
      bus_addr  <= addr_n;
      bus_re    <= (state_n == F_POLL_RD) || (state_n == F_REL_RD) ||
                   (state_n == F_HI_RD)   || (state_n == F_LO_RD);
      bus_we    <= (state_n == F_ACK0) || (state_n == F_ACK1);
      bus_wdata <= (state_n == F_ACK1) ? DATA_W'(1) : '0;
      if (state == F_IDLE && go) begin
        stream_q <= want_stream;
        hi_q     <= '0;
      end
      if (state == F_HI_WT) hi_q <= bus_rdata;
      if (state == F_LO_WT) lo_q <= bus_rdata;
    end
  end

  assign word = {hi_q, lo_q};
endmodule

// File: rtl/phy_mon_cnt.sv
module phy_mon_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec && left_q != '0) left_q <= left_q - W'(1);
  end

  assign last = (left_q == W'(1));
endmodule

// File: rtl/phy_msg_monitor.sv
module phy_msg_monitor
  import phy_mon_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int STATUS_ADDR = 16,
  parameter int LO_ADDR     = 32,
  parameter int HI_ADDR     = 33,
  parameter int ACK_ADDR    = 48,
  parameter int READY_BIT   = 0,
  parameter int CODE_PASS   = 8'h07,
  parameter int CODE_STREAM = 8'h08,
  parameter int CODE_FAIL   = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_we,
  output logic                  bus_re,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  train_done,
  output logic                  train_fail,
  output logic [2*DATA_W-1:0]   stream_word,
  output logic                  stream_valid
);
  localparam int WORD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] K_PASS   = DATA_W'(CODE_PASS);
  localparam logic [DATA_W-1:0] K_STREAM = DATA_W'(CODE_STREAM);
  localparam logic [DATA_W-1:0] K_FAIL   = DATA_W'(CODE_FAIL);

  ctl_st_t state;
  logic go_q, want_q;
  logic f_done;
  logic [WORD_W-1:0] f_word;
  logic [DATA_W-1:0] low_half;
  logic cnt_load, cnt_dec, cnt_last;

  assign low_half = f_word[DATA_W-1:0];
  assign cnt_load = (state == S_CNT) && f_done && (low_half != '0);
  assign cnt_dec  = (state == S_DRAIN) && f_done;

  phy_mon_fetch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .ACK_ADDR(ACK_ADDR),
    .READY_BIT(READY_BIT)
  ) u_fetch (
    .clk(clk), .rst(rst), .go(go_q), .want_stream(want_q),
    .done(f_done), .word(f_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  phy_mon_cnt #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(low_half),
    .dec(cnt_dec), .last(cnt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      go_q         <= 1'b0;
      want_q       <= 1'b0;
      train_done   <= 1'b0;
      train_fail   <= 1'b0;
      stream_valid <= 1'b0;
      stream_word  <= '0;
    end else begin
      go_q         <= 1'b0;
      stream_valid <= 1'b0;
      unique case (state)
        S_IDLE, S_HALT: begin
          if (start) begin
            state      <= S_ID;
            go_q       <= 1'b1;
            want_q     <= 1'b0;
            train_done <= 1'b0;
            train_fail <= 1'b0;
          end
        end
        S_ID: begin
          if (f_done) begin
            if (low_half == K_PASS) begin
              state      <= S_HALT;
              train_done <= 1'b1;
            end else if (low_half == K_FAIL) begin
              state      <= S_HALT;
              train_fail <= 1'b1;
            end else if (low_half == K_STREAM) begin
              state  <= S_CNT;
              go_q   <= 1'b1;
              want_q <= 1'b1;
            end else begin
              go_q   <= 1'b1;
              want_q <= 1'b0;
            end
          end
        end
        S_CNT: begin
          if (f_done) begin
            stream_valid <= 1'b1;
            stream_word  <= f_word;
            go_q         <= 1'b1;
            if (low_half == '0) begin
              state  <= S_ID;
              want_q <= 1'b0;
            end else begin
              state  <= S_DRAIN;
              want_q <= 1'b1;
            end
          end
        end
        S_DRAIN: begin
          if (f_done) begin
            stream_valid <= 1'b1;
            stream_word  <= f_word;
            go_q         <= 1'b1;
            if (cnt_last) begin
              state  <= S_ID;
              want_q <= 1'b0;
            end else begin
              want_q <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_msg_monitor_chk.sv
module phy_msg_monitor_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int ACK_ADDR = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              train_done,
  input logic              train_fail,
  input logic              stream_valid
);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(ACK_ADDR);
  logic ack_low_seen;
  logic ack_wr;

  assign ack_wr = bus_we && (bus_addr == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) ack_low_seen <= 1'b0;
    else if (ack_wr) ack_low_seen <= (bus_wdata == '0);
  end

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst) !(bus_re && bus_we)); // R11
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(train_done && train_fail)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) train_done && !start |=> train_done); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst) train_fail && !start |=> train_fail); // R8
  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (rst) train_fail |-> !bus_re && !bus_we); // R8
  AST_ACK_ORDER: assert property (@(posedge clk) disable iff (rst) ack_wr && bus_wdata != '0 |-> ack_low_seen); // R6
  AST_STREAM_IN_RUN: assert property (@(posedge clk) disable iff (rst) stream_valid |-> !train_done && !train_fail); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst) start && (train_done || train_fail) |=> !train_done && !train_fail); // R12
endmodule

bind phy_msg_monitor phy_msg_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_ADDR(ACK_ADDR)
) u_chk (.*);

// File: tb/phy_msg_monitor_tb.sv
module phy_msg_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic bus_we, bus_re;
  logic [15:0] bus_rdata;
  logic train_done, train_fail;
  logic [31:0] stream_word;
  logic stream_valid;

  int checks = 0;
  int fails = 0;
  int accesses = 0;
  int hi_reads = 0;
  int lo_reads = 0;

  logic [31:0] phy_q[$];
  logic [31:0] exp_q[$];
  bit pend = 0, ack0 = 0, rel_seen = 0;
  int gap = 0, rel_cnt = 0;

  always #5 clk = ~clk;

  phy_msg_monitor u_dut (
    .clk(clk), .rst(rst), .start(start), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .train_done(train_done), .train_fail(train_fail),
    .stream_word(stream_word), .stream_valid(stream_valid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY mailbox model: status bit0 low = pending; release shown after a delay
  always @(posedge clk) begin
    if (rst) begin
      pend = 0; ack0 = 0; rel_seen = 0; gap = 0; rel_cnt = 0;
      bus_rdata <= '0;
    end else begin
      if (bus_re) begin
        accesses++;
        case (bus_addr)
          8'h10: begin
            if (pend) bus_rdata <= 16'h0000;
            else if (ack0) begin
              bus_rdata <= (rel_cnt >= 2) ? 16'h0001 : 16'h0000;
              if (rel_cnt >= 2) rel_seen = 1;
            end else bus_rdata <= 16'h0001;
          end
          8'h20: begin
            lo_reads++;
            check(pend, "R3 lo read while pending", 32'(pend), 1);
            bus_rdata <= (phy_q.size() > 0) ? phy_q[0][15:0] : 16'h0;
          end
          8'h21: begin
            hi_reads++;
            check(pend, "R3 hi read while pending", 32'(pend), 1);
            bus_rdata <= (phy_q.size() > 0) ? phy_q[0][31:16] : 16'h0;
          end
          default: check(0, "R11 read address legal", 32'(bus_addr), 32'h10);
        endcase
      end
      if (bus_we) begin
        accesses++;
        check(bus_addr == 8'h30, "R6 write address", 32'(bus_addr), 32'h30);
        if (bus_wdata == 16'h0) begin
          check(pend, "R6 ack0 after message", 32'(pend), 1);
          pend = 0; ack0 = 1; rel_cnt = 0; rel_seen = 0;
        end else begin
          check(ack0 && rel_seen, "R6 ack1 after release", 32'(rel_seen), 1);
          ack0 = 0;
          if (phy_q.size() > 0) void'(phy_q.pop_front());
          gap = 3;
        end
      end
      if (ack0) rel_cnt++;
      if (!pend && !ack0) begin
        if (gap > 0) gap--;
        else if (phy_q.size() > 0) pend = 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && stream_valid) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected stream word", stream_word, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(stream_word == e, "R9 R5 stream word", stream_word, e);
      end
    end
  end

  task automatic post(input logic [31:0] w, input bit is_stream);
    phy_q.push_back(w);
    if (is_stream) exp_q.push_back(w);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (train_done || train_fail) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int acc_snap;
    repeat (3) @(negedge clk);
    check(!train_done && !train_fail && !stream_valid && !bus_re && !bus_we,
          "R1 reset outputs", {train_done, train_fail, stream_valid, bus_re, bus_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!train_done && !train_fail && !bus_re && !bus_we, "R1 after reset",
          {train_done, train_fail, bus_re, bus_we}, 0);

    post(32'h0000_0012, 0);
    repeat (20) @(negedge clk);
    check(accesses == 0, "R2 idle without start", accesses, 0);

    post(32'h0000_0008, 0);
    post(32'hABCD_0003, 1);
    post(32'h1111_2222, 1);
    post(32'h3333_4444, 1);
    post(32'h0000_FFFF, 1);
    post(32'h0000_0007, 0);
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();  // R12 ignored while busy
    wait_end();
    check(train_done && !train_fail, "R7 pass code", {train_done, train_fail}, 2'b10);
    check(exp_q.size() == 0, "R9 all stream words seen", exp_q.size(), 0);
    check(hi_reads == 4, "R5 high reads only for stream words", hi_reads, 4);
    check(lo_reads == 7, "R4 R10 low reads per message", lo_reads, 7);
    check(stream_word == 32'h0000_FFFF, "R9 last stream word", stream_word, 32'h0000_FFFF);
    repeat (20) @(negedge clk);
    check(train_done, "R7 done sticky", train_done, 1);

    post(32'h0000_0008, 0);
    post(32'h5555_0000, 1);
    post(32'h0000_00FF, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!train_done && !train_fail, "R12 start clears flags", {train_done, train_fail}, 0);
    wait_end();
    check(train_fail && !train_done, "R8 fail code", {train_done, train_fail}, 2'b01);
    check(exp_q.size() == 0, "R9 zero-length stream", exp_q.size(), 0);
    acc_snap = accesses;
    post(32'h0000_0007, 0);
    repeat (50) @(negedge clk);
    check(accesses == acc_snap, "R8 bus silent after fail", accesses, acc_snap);
    check(train_fail, "R8 fail sticky", train_fail, 1);

    pulse_start();
    check(!train_fail, "R12 start clears fail", train_fail, 0);
    wait_end();
    check(train_done && !train_fail, "R7 R12 pass after restart", {train_done, train_fail}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule